// File: doc/BRIEF.md
# Data EEPROM Control Register Sequencer

This block places a small non-volatile byte array behind five byte-wide registers on a simple bus (address, write strobe, read strobe, write data, read data). Software loads an address register and a data register, then raises request bits in a control register. A read request copies the addressed byte into the data register at once. A write request programs the byte over a fixed number of clock cycles. A write only starts when a two-step unlock pattern has been written just before it.

When a write finishes, the block raises an interrupt flag, which stays set until software clears it. A warm reset (master clear or watchdog) that lands while a write is running aborts it and sets an error flag. That flag survives every warm reset, but a power-on reset clears it. Any reset empties the data and address registers and drops the write enable. The array contents are not reset.

Register map (byte addresses): control `9Ch`, data `9Ah`, address `9Bh`, unlock `9Dh`, interrupt flag `0Ch`. The control byte holds read request in bit 0, write busy/request in bit 1, write enable in bit 2 and write error in bit 3. The flag register holds the interrupt flag in bit 0.

Top module: `eeprom_ctl_seq`

## Requirements
- R1: Control bits 7..4 always read 0. The unlock register always reads 00h. Unused bits of the flag register read 0.
- R2: A control write stores bit 3 (error) and, when no write is running, bit 2 (enable). Both read back in those positions.
- R3: Writing 0 to the request bits never clears them. While a write runs, bit 1 reads 1 whatever is written to the control register.
- R4: A control write with bit 0 set, when no write is running, loads the data register with the byte at the current address in the next cycle. Bit 0 then reads 0.
- R5: A write starts only when three bus writes follow one another with no other access between them: 55h to unlock, then AAh to unlock, then a control byte with bits 1 and 2 set. Cycles with no bus access may sit between these steps.
- R6: Any other bus access, read or write, in the middle of the unlock pattern cancels it, and the control write that follows starts nothing.
- R7: Control bit 1 reads 1 for exactly WRITE_CYCLES cycles, 16 by default. The data byte is then stored at the address and the interrupt flag is set.
- R8: While a write runs, writes to the data register, to the address register and to control bits 0 and 2 are ignored.
- R9: The interrupt flag stays set until software writes 0 to flag bit 0.
- R10: A warm reset during a write sets the error flag and leaves the array byte unchanged. The error flag survives warm resets. A power-on reset clears it.
- R11: Any reset clears the data register, the address register and the interrupt flag.
- R12: The write enable bit is 0 after power-on reset. A control write with bit 1 set and bit 2 clear starts no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Synchronous active-high power-on reset |
| rst_warm | input | 1 | Synchronous active-high warm reset (master clear or watchdog) |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| wr_irq | output | 1 | Write-complete interrupt flag |

## Verification
The bench writes and reads back every array location with a computed pattern and measures the busy window of each write to the cycle. A timer that is off by one would show 15 or 17 busy cycles. The unlock pattern is tested with a stray read in the middle, with a stray write in the middle, in the wrong order, with the enable bit clear, and with idle gaps between the steps. A careless unlock would program the array in one of the broken cases, or refuse the case with idle gaps. A warm reset is applied in the middle of a write. A design that let the write finish, or that cleared the error flag on that reset, would show a changed byte or a 0 in bit 3. Writes made during a busy window are checked to change neither the target byte nor the busy bit.

// File: rtl/eectl_pkg.sv
package eectl_pkg;

    localparam logic [7:0] REG_DATA   = 8'h9A;
    localparam logic [7:0] REG_ADDR   = 8'h9B;
    localparam logic [7:0] REG_CTRL   = 8'h9C;
    localparam logic [7:0] REG_UNLOCK = 8'h9D;
    localparam logic [7:0] REG_FLAG   = 8'h0C;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_GOT1  = 2'd1,
        UL_ARMED = 2'd2
    } unlock_state_t;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] addr;
        logic [7:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic err;
        logic wren;
    } ctrl_state_t;

    function automatic logic [7:0] ctrl_byte(input ctrl_state_t c, input logic busy);
        return {4'b0000, c.err, c.wren, busy, 1'b0};
    endfunction

endpackage

// File: rtl/eectl_unlock.sv
module eectl_unlock
    import eectl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     armed
);
    unlock_state_t state_q, state_d;
    logic          is_unlock_wr;

    assign is_unlock_wr = req.wr && (req.addr == REG_UNLOCK);

    always_comb begin
        state_d = state_q;
        if (req.wr || req.rd) begin
            if (is_unlock_wr && req.wdata == KEY_FIRST)
                state_d = UL_GOT1;
            else if (state_q == UL_GOT1 && is_unlock_wr && req.wdata == KEY_SECOND)
                state_d = UL_ARMED;
            else
                state_d = UL_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= UL_IDLE;
        else     state_q <= state_d;
    end

    assign armed = (state_q == UL_ARMED);

    // R5: the armed state is reached only through the first key step
    a_r5_armed_path: assert property (@(posedge clk) disable iff (rst)
        (state_q == UL_ARMED) |-> ($past(state_q) == UL_GOT1 || $past(state_q) == UL_ARMED));

    // R6: any access in the armed state leaves it
    a_r6_access_disarms: assert property (@(posedge clk) disable iff (rst)
        (armed && (req.wr || req.rd) && !(req.wr && req.addr == REG_UNLOCK && req.wdata == KEY_FIRST))
        |=> (state_q == UL_IDLE));
endmodule

// File: rtl/eectl_timer.sv
module eectl_timer #(
    parameter int WRITE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_LOAD;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // R3: busy cannot drop before the count runs out
    a_r3_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0) |=> busy_q);

    // R7: the terminal count ends the write
    a_r7_done_ends: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy_q);
endmodule

// File: rtl/eectl_array.sv
module eectl_array #(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[idx] <= wdata;
    end

    assign rdata = cells[idx];
endmodule

// File: rtl/eeprom_ctl_seq.sv
module eeprom_ctl_seq
    import eectl_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int WRITE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_por,
    input  logic       rst_warm,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       wr_irq
);
    localparam int AW = $clog2(DEPTH);

    bus_req_t    req;
    ctrl_state_t ctrl_q;
    logic [7:0]  data_q;
    logic [AW-1:0] addr_q;
    logic        irq_q;
    logic        rst_any;
    logic        armed, busy, done, start;
    logic [7:0]  mem_rdata;
    logic        ctrl_wr;

    assign req     = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, wdata: bus_wdata};
    assign rst_any = rst_por | rst_warm;
    assign ctrl_wr = bus_wr && (bus_addr == REG_CTRL);
    assign start   = armed && ctrl_wr && bus_wdata[1] && bus_wdata[2] && !busy;

    eectl_unlock u_unlock (
        .clk   (clk),
        .rst   (rst_any),
        .req   (req),
        .armed (armed)
    );

    eectl_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst_any),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    eectl_array #(.DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .we    (done && !rst_any),
        .idx   (addr_q),
        .wdata (data_q),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst_por) begin
            ctrl_q <= '0;
            data_q <= '0;
            addr_q <= '0;
            irq_q  <= 1'b0;
        end else if (rst_warm) begin
            ctrl_q.wren <= 1'b0;
            if (busy) ctrl_q.err <= 1'b1;
            data_q <= '0;
            addr_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (bus_wr) begin
                unique case (bus_addr)
                    REG_DATA: if (!busy) data_q <= bus_wdata;
                    REG_ADDR: if (!busy) addr_q <= bus_wdata[AW-1:0];
                    REG_CTRL: begin
                        ctrl_q.err <= bus_wdata[3];
                        if (!busy) begin
                            ctrl_q.wren <= bus_wdata[2];
                            if (bus_wdata[0]) data_q <= mem_rdata;
                        end
                    end
                    REG_FLAG: irq_q <= bus_wdata[0];
                    default: ;
                endcase
            end
            if (done) irq_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (bus_addr)
            REG_DATA: bus_rdata = data_q;
            REG_ADDR: bus_rdata = 8'(addr_q);
            REG_CTRL: bus_rdata = ctrl_byte(ctrl_q, busy);
            REG_FLAG: bus_rdata = {7'b0, irq_q};
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign wr_irq = irq_q;

    // R1: high control bits are never driven
    a_r1_ctrl_upper_zero: assert property (@(posedge clk) disable iff (rst_any)
        (bus_addr == REG_CTRL) |-> (bus_rdata[7:4] == 4'h0));

    // R5: a write begins only from the armed unlock state
    a_r5_start_needs_arm: assert property (@(posedge clk) disable iff (rst_any)
        $rose(busy) |-> $past(armed));

    // R8: operands stay frozen while programming
    a_r8_operands_frozen: assert property (@(posedge clk) disable iff (rst_any)
        (busy && $past(busy)) |-> ($stable(addr_q) && $stable(data_q)));

    // R10: a warm reset during a write leaves the error flag set
    a_r10_err_on_abort: assert property (@(posedge clk) disable iff (rst_por)
        (rst_warm && busy) |=> ctrl_q.err);

    // R7: completion raises the interrupt flag
    a_r7_irq_on_done: assert property (@(posedge clk) disable iff (rst_any)
        done |=> irq_q);
endmodule

// File: tb/sim_eeprom_ctl_seq.sv
module sim_eeprom_ctl_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int WCYC       = 16;

    localparam logic [7:0] A_DATA = 8'h9A;
    localparam logic [7:0] A_ADDR = 8'h9B;
    localparam logic [7:0] A_CTRL = 8'h9C;
    localparam logic [7:0] A_UNLK = 8'h9D;
    localparam logic [7:0] A_FLAG = 8'h0C;

    logic       clk = 1'b0;
    logic       rst_por, rst_warm, bus_wr, bus_rd;
    logic [7:0] bus_addr, bus_wdata;
    logic [7:0] bus_rdata;
    logic       wr_irq;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_ctl_seq #(.DEPTH(DEPTH), .WRITE_CYCLES(WCYC)) u0 (
        .clk(clk), .rst_por(rst_por), .rst_warm(rst_warm),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_irq(wr_irq)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 7) ^ 8'h5A);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic start_write(input logic [7:0] a, input logic [7:0] d);
        wr(A_ADDR, a); wr(A_DATA, d);
        wr(A_UNLK, 8'h55); wr(A_UNLK, 8'hAA);
        wr(A_CTRL, 8'h06);
    endtask

    task automatic busy_len(output int n);
        logic [7:0] v;
        n = 0;
        for (int i = 0; i < 4 * WCYC; i++) begin
            peek(A_CTRL, v);
            if (!v[1]) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_mem(input logic [7:0] a, output logic [7:0] v);
        wr(A_ADDR, a); wr(A_CTRL, 8'h01);
        peek(A_DATA, v);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        rst_por = 1'b1; rst_warm = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = 8'h00; bus_wdata = 8'h00;
        idle(3);
        rst_por = 1'b0;
        @(negedge clk);

        // R12 / R11: reset state
        peek(A_CTRL, v); chk("R12 ctrl after por", v, 8'h00);
        peek(A_DATA, v); chk("R11 data after por", v, 8'h00);
        peek(A_ADDR, v); chk("R11 addr after por", v, 8'h00);
        peek(A_FLAG, v); chk("R11 flag after por", v, 8'h00);

        // R1 / R2: unimplemented bits, stored bits
        wr(A_CTRL, 8'hFC);
        peek(A_CTRL, v); chk("R1 R2 ctrl readback", v, 8'h0C);
        wr(A_UNLK, 8'h55);
        peek(A_UNLK, v); chk("R1 unlock reads zero", v, 8'h00);
        wr(A_FLAG, 8'hFE);
        peek(A_FLAG, v); chk("R1 flag upper bits", v, 8'h00);
        wr(A_CTRL, 8'h00);

        // R7 / R9: program every location, measure busy window
        for (int a = 0; a < DEPTH; a++) begin
            start_write(8'(a), pat(a));
            busy_len(n);
            chk("R7 busy cycles", 8'(n), 8'(WCYC));
            peek(A_FLAG, v); chk("R7 irq after write", v, 8'h01);
            wr(A_FLAG, 8'h00);
            peek(A_FLAG, v); chk("R9 irq cleared by software", v, 8'h00);
        end

        // R4: read back every location
        for (int a = 0; a < DEPTH; a++) begin
            read_mem(8'(a), v); chk("R4 read data", v, pat(a));
            peek(A_CTRL, v); chk("R4 read bit self-clears", v & 8'h01, 8'h00);
        end

        // R3 / R8: writes during a running write
        start_write(8'h05, 8'h11);
        wr(A_CTRL, 8'h00);
        peek(A_CTRL, v); chk("R3 request bit not cleared", v, 8'h06);
        wr(A_DATA, 8'hEE); wr(A_ADDR, 8'h09);
        peek(A_DATA, v); chk("R8 data frozen", v, 8'h11);
        peek(A_ADDR, v); chk("R8 addr frozen", v, 8'h05);
        busy_len(n);
        read_mem(8'h05, v); chk("R8 target written", v, 8'h11);
        read_mem(8'h09, v); chk("R8 other untouched", v, pat(9));

        // R9: flag holds over idle cycles
        idle(20);
        peek(A_FLAG, v); chk("R9 irq held", v, 8'h01);
        chk("R9 irq pin held", {7'b0, wr_irq}, 8'h01);
        wr(A_FLAG, 8'h00);

        // R12: enable clear blocks the write
        wr(A_ADDR, 8'h02); wr(A_DATA, 8'h77);
        wr(A_UNLK, 8'h55); wr(A_UNLK, 8'hAA); wr(A_CTRL, 8'h02);
        peek(A_CTRL, v); chk("R12 no start without enable", v & 8'h02, 8'h00);
        idle(WCYC + 2);
        read_mem(8'h02, v); chk("R12 byte unchanged", v, pat(2));

        // R6: stray read in the middle
        wr(A_ADDR, 8'h02); wr(A_DATA, 8'h77);
        wr(A_UNLK, 8'h55); rd(A_DATA); wr(A_UNLK, 8'hAA); wr(A_CTRL, 8'h06);
        peek(A_CTRL, v); chk("R6 stray read aborts", v & 8'h02, 8'h00);
        // R6: stray write in the middle
        wr(A_UNLK, 8'h55); wr(A_UNLK, 8'hAA); wr(A_DATA, 8'h77); wr(A_CTRL, 8'h06);
        peek(A_CTRL, v); chk("R6 stray write aborts", v & 8'h02, 8'h00);
        // R5: wrong key order
        wr(A_UNLK, 8'hAA); wr(A_UNLK, 8'h55); wr(A_CTRL, 8'h06);
        peek(A_CTRL, v); chk("R5 wrong order", v & 8'h02, 8'h00);
        idle(WCYC + 2);
        read_mem(8'h02, v); chk("R6 byte unchanged", v, pat(2));

        // R5: idle gaps between steps are allowed
        wr(A_ADDR, 8'h02); wr(A_DATA, 8'h77);
        wr(A_UNLK, 8'h55); idle(3); wr(A_UNLK, 8'hAA); idle(2); wr(A_CTRL, 8'h06);
        peek(A_CTRL, v); chk("R5 start with gaps", v & 8'h02, 8'h02);
        busy_len(n);
        read_mem(8'h02, v); chk("R5 byte written", v, 8'h77);
        wr(A_FLAG, 8'h00);

        // R10 / R11: warm reset during a write
        start_write(8'h07, 8'hC3);
        idle(4);
        rst_warm = 1'b1; @(negedge clk); rst_warm = 1'b0;
        peek(A_CTRL, v); chk("R10 error set, busy and enable clear", v, 8'h08);
        peek(A_DATA, v); chk("R11 data after warm", v, 8'h00);
        peek(A_ADDR, v); chk("R11 addr after warm", v, 8'h00);
        peek(A_FLAG, v); chk("R11 flag after warm", v, 8'h00);
        idle(WCYC + 2);
        rst_warm = 1'b1; @(negedge clk); rst_warm = 1'b0;
        peek(A_CTRL, v); chk("R10 error survives warm", v, 8'h08);
        rst_por = 1'b1; @(negedge clk); rst_por = 1'b0;
        peek(A_CTRL, v); chk("R10 por clears error", v, 8'h00);
        read_mem(8'h07, v); chk("R10 aborted byte unchanged", v, pat(7));

        finished = 1'b1;
        summary();
    end
endmodule